// File: doc/BRIEF.md
# Legacy Port Write Trap Unit

This block sits on a byte-wide I/O bus next to a display controller that is not register-compatible with an older colour adapter. Software that still programs the older adapter writes into a 16-port legacy window. This unit does not act on those writes as register accesses. It records which port was hit and what byte was written. When trapping is armed, it then raises a non-maskable interrupt so that firmware can emulate the access in software.

Firmware reaches the unit through a second 16-port native window. There it sets the control register that arms trapping, reads the captured byte and port, acknowledges the capture flag and drops the interrupt. It also reads a status byte that combines the upper control bits with live display status. The unit keeps a shadow byte for the old CRTC data ports. On the legacy status port it gives a sensible answer even while the display is off: the sync bits alternate on each read, so an early host poll sees a working adapter.

Read data is registered. A read strobe sampled at a rising clock edge places its result on the read-data output at that same edge. The output then holds until the next read.

Top module: `legacy_port_trap`

## Requirements
- R1: Any write whose address falls in the legacy window (default base 0x3D0, 16 ports) stores the address bits 3..0 in bits 3..0 of the captured-port register and the written byte in the captured-data register.
- R2: On a legacy write, if `trap_global_en` is 1 and control bit 5 is 1, bit 7 of the captured-port register is set and `nmi_req` goes to 1 after that edge. Otherwise bit 7 is written 0 and `nmi_req` keeps its value.
- R3: A read of native offset 0xB returns the captured-data byte. A read of native offset 0xC returns the captured-port register, with the trap flag in bit 7, zeros in bits 6..4 and the port nibble in bits 3..0.
- R4: A write to native offset 0xB clears only the trap flag (bit 7 of the captured-port register). `nmi_req` and the nibble are unchanged.
- R5: A write to native offset 0xC clears both the trap flag and `nmi_req`.
- R6: `nmi_req` is a level that stays 1 until cleared by R5. A later trapped write replaces the captured nibble and byte.
- R7: A write to legacy offset 1 also stores the byte in a shadow register. Reads of legacy offsets 1, 3, 5 and 7 return the shadow. Writes to other legacy offsets leave it unchanged.
- R8: A write to native offset 9 loads the control register. A read of native offset 0xA returns control bits 7..5 in bits 7..5 and `live_stat[4:0]` in bits 4..0.
- R9: With `disp_enable` at 0, each read of legacy offset 0xA inverts bits 3 and 0 of an internal toggle byte (reset 0x00) and returns the new value: 0x09, 0x00, 0x09, and so on.
- R10: With `disp_enable` at 1, a read of legacy offset 0xA returns `{4'b0, live_stat[4], live_stat[2:0]}` and leaves the toggle byte unchanged.
- R11: Reads return 0xFF for native offsets other than 0xA, 0xB and 0xC, for legacy offsets other than 1, 3, 5, 7 and 0xA, and for addresses outside both windows.
- R12: Synchronous active-low reset clears the capture registers, flag, shadow, control register, toggle byte, `nmi_req` and `io_rdata` (to 0x00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_addr | input | ADDR_W (10) | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| trap_global_en | input | 1 | Global permission for trapping |
| disp_enable | input | 1 | Display-enable mode bit from the mode logic |
| live_stat | input | 5 | Live display status bits |
| nmi_req | output | 1 | Non-maskable interrupt request level |

## Verification
The embedded properties check the following on every cycle:
- a trapped write raises the flag and the interrupt;
- an untrapped write clears the flag without touching the interrupt;
- the interrupt holds until the offset 0xC acknowledge;
- the offset 0xB acknowledge leaves the interrupt alone;
- the shadow changes only on legacy offset 1 writes;
- stray addresses read back 0xFF.

The bench scenarios alone show that the read-back values line up with the capture in the right bit positions. They also show the alternating 0x09/0x00 sequence on the legacy status port, and the way the native status byte merges control and live bits. These come from directed cases and a seeded random mix of windows, offsets, enables and live status, compared against a bench-side model.

// File: rtl/legacy_trap_pkg.sv
// Package: shared offsets and constants for the legacy port trap unit.
// Assumes 16-port windows whose bases are aligned to 16.
package legacy_trap_pkg;

    localparam int DATA_W    = 8;
    localparam int OFF_W     = 4;
    localparam int LSTAT_W   = 5;

    // Native window offsets
    localparam logic [OFF_W-1:0] NOFF_CTRL   = 4'h9;
    localparam logic [OFF_W-1:0] NOFF_STATUS = 4'hA;
    localparam logic [OFF_W-1:0] NOFF_DATA   = 4'hB;
    localparam logic [OFF_W-1:0] NOFF_PORT   = 4'hC;

    // Legacy window offsets
    localparam logic [OFF_W-1:0] LOFF_CRTC_DATA = 4'h1;
    localparam logic [OFF_W-1:0] LOFF_STATUS    = 4'hA;

    // Control register bit that arms trapping
    localparam int CTL_ARM_BIT = 5;

    // Bits toggled by the legacy status poll while the display is off
    localparam logic [DATA_W-1:0] SYNC_TOGGLE = 8'h09;

    localparam logic [DATA_W-1:0] RD_IDLE = 8'hFF;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_SHADOW,
        SRC_LSTAT,
        SRC_NSTAT,
        SRC_CDATA,
        SRC_CPORT
    } rd_src_e;

endpackage

// File: rtl/ltrap_addr_dec.sv
// Module: ltrap_addr_dec
// Decodes an I/O address into legacy-window and native-window hits plus the
// 4-bit offset. Assumes both bases are multiples of 16 and do not overlap.
module ltrap_addr_dec #(
    parameter int ADDR_W   = 10,
    parameter int LEG_BASE = 'h3D0,
    parameter int NAT_BASE = 'h2D0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              leg_hit,
    output logic              nat_hit,
    output logic [3:0]        offset
);
    import legacy_trap_pkg::*;

    localparam int HI_W = ADDR_W - OFF_W;
    localparam logic [HI_W-1:0] LEG_HI = HI_W'(LEG_BASE >> OFF_W);
    localparam logic [HI_W-1:0] NAT_HI = HI_W'(NAT_BASE >> OFF_W);

    // Compare the upper address bits against each window base
    always_comb begin
        leg_hit = (addr[ADDR_W-1:OFF_W] == LEG_HI);
        nat_hit = (addr[ADDR_W-1:OFF_W] == NAT_HI);
        offset  = addr[OFF_W-1:0];
    end
endmodule

// File: rtl/ltrap_ctrl_reg.sv
// Module: ltrap_ctrl_reg
// Holds the firmware control byte written at the native control offset.
// Assumes one write strobe per access; reset value is zero (trap disarmed).
module ltrap_ctrl_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:0] wdata,
    output logic [7:0] ctl_q
);
    // Load the control byte on a native control write
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (ctl_wr)
            ctl_q <= wdata;
    end

    // R8: the register only changes on its own write strobe
    p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(ctl_q));
endmodule

// File: rtl/ltrap_capture.sv
// Module: ltrap_capture
// Latches the port nibble and byte of every legacy write, keeps the trap
// flag and the level interrupt request, and the CRTC data shadow byte.
// Assumes at most one write strobe per cycle.
module ltrap_capture (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       leg_wr,
    input  logic [3:0] offset,
    input  logic [7:0] wdata,
    input  logic       trap_en,
    input  logic       clr_flag,
    input  logic       clr_nmi,
    output logic [7:0] cap_port,
    output logic [7:0] cap_data,
    output logic [7:0] shadow,
    output logic       nmi
);
    import legacy_trap_pkg::*;

    logic       flag_q;
    logic [3:0] nib_q;

    // Capture nibble and data byte on any legacy write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nib_q    <= '0;
            cap_data <= '0;
        end else if (leg_wr) begin
            nib_q    <= offset;
            cap_data <= wdata;
        end
    end

    // Trap flag: written on legacy write, cleared by either acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (leg_wr)
            flag_q <= trap_en;
        else if (clr_flag || clr_nmi)
            flag_q <= 1'b0;
    end

    // Interrupt level: set by trapped write, held until cleared
    always_ff @(posedge clk) begin
        if (!rst_n)
            nmi <= 1'b0;
        else if (leg_wr && trap_en)
            nmi <= 1'b1;
        else if (clr_nmi)
            nmi <= 1'b0;
    end

    // Shadow byte for CRTC data reads, written only at legacy offset 1
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow <= '0;
        else if (leg_wr && offset == LOFF_CRTC_DATA)
            shadow <= wdata;
    end

    // Assemble the captured-port byte
    always_comb cap_port = {flag_q, 3'b000, nib_q};

    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        leg_wr |=> (cap_port[3:0] == $past(offset)) && (cap_data == $past(wdata)));

    p_trap_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        leg_wr && trap_en |=> nmi && cap_port[7]);

    p_untrapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        leg_wr && !trap_en |=> !cap_port[7] && (nmi == $past(nmi)));

    p_ack_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_flag && !leg_wr |=> !cap_port[7] && (nmi == $past(nmi)));

    p_ack_nmi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_nmi && !leg_wr |=> !nmi && !cap_port[7]);

    p_nmi_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nmi && !clr_nmi |=> nmi);

    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(leg_wr && offset == LOFF_CRTC_DATA) |=> $stable(shadow));
endmodule

// File: rtl/ltrap_status_gen.sv
// Module: ltrap_status_gen
// Builds the native status byte and the legacy status byte. While the
// display is off the legacy byte comes from a toggle register that flips
// its sync bits on every poll. Assumes poll is a one-cycle read strobe.
module ltrap_status_gen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       leg_poll,
    input  logic       disp_enable,
    input  logic [4:0] live_stat,
    input  logic [7:0] ctl_q,
    output logic [7:0] nat_stat,
    output logic [7:0] leg_stat
);
    import legacy_trap_pkg::*;

    logic [7:0] tog_q;

    // Flip the sync bits on each poll made while the display is off
    always_ff @(posedge clk) begin
        if (!rst_n)
            tog_q <= '0;
        else if (leg_poll && !disp_enable)
            tog_q <= tog_q ^ SYNC_TOGGLE;
    end

    // Compose both status views
    always_comb begin
        nat_stat = {ctl_q[7:5], live_stat};
        if (disp_enable)
            leg_stat = {4'b0000, live_stat[4], live_stat[2:0]};
        else
            leg_stat = tog_q ^ SYNC_TOGGLE;
    end

    p_toggle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        disp_enable |=> $stable(tog_q));
endmodule

// File: rtl/ltrap_read_mux.sv
// Module: ltrap_read_mux
// Selects the read source from the decoded window and offset and registers
// it onto the read-data output. Output holds between reads.
module ltrap_read_mux (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd,
    input  logic       leg_hit,
    input  logic       nat_hit,
    input  logic [3:0] offset,
    input  logic [7:0] shadow,
    input  logic [7:0] leg_stat,
    input  logic [7:0] nat_stat,
    input  logic [7:0] cap_data,
    input  logic [7:0] cap_port,
    output logic [7:0] rdata
);
    import legacy_trap_pkg::*;

    rd_src_e    src;
    logic [7:0] sel;

    // Pick the source for this address
    always_comb begin
        src = SRC_NONE;
        if (nat_hit) begin
            case (offset)
                NOFF_STATUS: src = SRC_NSTAT;
                NOFF_DATA:   src = SRC_CDATA;
                NOFF_PORT:   src = SRC_CPORT;
                default:     src = SRC_NONE;
            endcase
        end else if (leg_hit) begin
            if (offset == LOFF_STATUS)
                src = SRC_LSTAT;
            else if (offset[3] == 1'b0 && offset[0] == 1'b1)
                src = SRC_SHADOW;
        end
    end

    // Map the source to a byte
    always_comb begin
        case (src)
            SRC_SHADOW: sel = shadow;
            SRC_LSTAT:  sel = leg_stat;
            SRC_NSTAT:  sel = nat_stat;
            SRC_CDATA:  sel = cap_data;
            SRC_CPORT:  sel = cap_port;
            default:    sel = RD_IDLE;
        endcase
    end

    // Register the selected byte on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd)
            rdata <= sel;
    end

    p_unmapped_ff_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd && !leg_hit && !nat_hit |=> rdata == 8'hFF);

    p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));
endmodule

// File: rtl/legacy_port_trap.sv
// Module: legacy_port_trap (top)
// Traps writes to a 16-port legacy video window, records port and data,
// raises a level NMI request when armed, and lets firmware read and clear
// the capture through a 16-port native window. Assumes single-cycle
// read and write strobes and one access per cycle.
module legacy_port_trap #(
    parameter int ADDR_W   = 10,
    parameter int LEG_BASE = 'h3D0,
    parameter int NAT_BASE = 'h2D0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              trap_global_en,
    input  logic              disp_enable,
    input  logic [4:0]        live_stat,
    output logic              nmi_req
);
    import legacy_trap_pkg::*;

    logic       leg_hit, nat_hit;
    logic [3:0] offset;
    logic [7:0] ctl_q, cap_port, cap_data, shadow, nat_stat, leg_stat;
    logic       leg_wr, ctl_wr, clr_flag, clr_nmi, trap_en, leg_poll;

    ltrap_addr_dec #(.ADDR_W(ADDR_W), .LEG_BASE(LEG_BASE), .NAT_BASE(NAT_BASE)) u_dec (
        .addr(io_addr), .leg_hit(leg_hit), .nat_hit(nat_hit), .offset(offset));

    // Strobe qualification per window and offset
    always_comb begin
        leg_wr   = io_wr && leg_hit;
        ctl_wr   = io_wr && nat_hit && offset == NOFF_CTRL;
        clr_flag = io_wr && nat_hit && offset == NOFF_DATA;
        clr_nmi  = io_wr && nat_hit && offset == NOFF_PORT;
        trap_en  = trap_global_en && ctl_q[CTL_ARM_BIT];
        leg_poll = io_rd && leg_hit && offset == LOFF_STATUS;
    end

    ltrap_ctrl_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wdata(io_wdata), .ctl_q(ctl_q));

    ltrap_capture u_cap (
        .clk(clk), .rst_n(rst_n), .leg_wr(leg_wr), .offset(offset), .wdata(io_wdata),
        .trap_en(trap_en), .clr_flag(clr_flag), .clr_nmi(clr_nmi),
        .cap_port(cap_port), .cap_data(cap_data), .shadow(shadow), .nmi(nmi_req));

    ltrap_status_gen u_stat (
        .clk(clk), .rst_n(rst_n), .leg_poll(leg_poll), .disp_enable(disp_enable),
        .live_stat(live_stat), .ctl_q(ctl_q), .nat_stat(nat_stat), .leg_stat(leg_stat));

    ltrap_read_mux u_rd (
        .clk(clk), .rst_n(rst_n), .rd(io_rd), .leg_hit(leg_hit), .nat_hit(nat_hit),
        .offset(offset), .shadow(shadow), .leg_stat(leg_stat), .nat_stat(nat_stat),
        .cap_data(cap_data), .cap_port(cap_port), .rdata(io_rdata));

    p_reset_quiet_r12: assert property (@(posedge clk)
        !rst_n |=> !nmi_req && io_rdata == 8'h00);
endmodule

// File: tb/legacy_port_trap_tb_top.sv
module legacy_port_trap_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] io_addr = '0;
    logic       io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic       trap_global_en = 1'b0, disp_enable = 1'b0;
    logic [4:0] live_stat = '0;
    logic       nmi_req;

    int errors = 0, checks = 0;

    // model state
    logic [3:0] m_nib = '0;
    logic [7:0] m_data = '0, m_shadow = '0, m_ctl = '0, m_tog = '0;
    logic       m_flag = 1'b0, m_nmi = 1'b0;

    always #2.5 clk = ~clk;

    legacy_port_trap dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .trap_global_en(trap_global_en),
        .disp_enable(disp_enable), .live_stat(live_stat), .nmi_req(nmi_req));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic bit is_leg(input logic [9:0] a); return a[9:4] == 6'h3D; endfunction
    function automatic bit is_nat(input logic [9:0] a); return a[9:4] == 6'h2D; endfunction

    function automatic string req_of(input logic [9:0] a);
        if (is_nat(a) && a[3:0] == 4'hA) return "R8";
        if (is_nat(a) && (a[3:0] == 4'hB || a[3:0] == 4'hC)) return "R3";
        if (is_leg(a) && a[3:0] == 4'hA) return disp_enable ? "R10" : "R9";
        if (is_leg(a) && a[3] == 1'b0 && a[0] == 1'b1) return "R7";
        return "R11";
    endfunction

    // model of a read; updates toggle state
    function automatic logic [7:0] exp_read(input logic [9:0] a);
        logic [3:0] o = a[3:0];
        if (is_nat(a)) begin
            if (o == 4'hA) return {m_ctl[7:5], live_stat};
            if (o == 4'hB) return m_data;
            if (o == 4'hC) return {m_flag, 3'b000, m_nib};
            return 8'hFF;
        end
        if (is_leg(a)) begin
            if (o == 4'hA) begin
                if (disp_enable) return {4'b0, live_stat[4], live_stat[2:0]};
                m_tog = m_tog ^ 8'h09;
                return m_tog;
            end
            if (o[3] == 1'b0 && o[0] == 1'b1) return m_shadow;
        end
        return 8'hFF;
    endfunction

    task automatic model_write(input logic [9:0] a, input logic [7:0] d);
        if (is_leg(a)) begin
            m_nib  = a[3:0];
            m_data = d;
            m_flag = trap_global_en && m_ctl[5];
            if (m_flag) m_nmi = 1'b1;
            if (a[3:0] == 4'h1) m_shadow = d;
        end else if (is_nat(a)) begin
            if (a[3:0] == 4'h9) m_ctl = d;
            if (a[3:0] == 4'hB) m_flag = 1'b0;
            if (a[3:0] == 4'hC) begin m_flag = 1'b0; m_nmi = 1'b0; end
        end
    endtask

    task automatic do_wr(input logic [9:0] a, input logic [7:0] d, input string req);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk);
        model_write(a, d);
        #1;
        chk({req, " nmi"}, {7'b0, nmi_req}, {7'b0, m_nmi});
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [9:0] a, input string req);
        logic [7:0] e;
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(posedge clk);
        e = exp_read(a);
        #1;
        chk(req, io_rdata, e);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    initial begin : watchdog
        #900000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(posedge clk);
        #1;
        chk("R12 reset nmi", {7'b0, nmi_req}, 8'h00);
        chk("R12 reset rdata", io_rdata, 8'h00);
        @(negedge clk) rst_n = 1'b1;
        do_rd(10'h2DC, "R12 port after reset");
        do_rd(10'h2DB, "R12 data after reset");
        do_rd(10'h3D3, "R12 shadow after reset");

        // armed trap
        trap_global_en = 1'b1;
        do_wr(10'h2D9, 8'h20, "R8");
        do_wr(10'h3D5, 8'hA7, "R2 trapped");
        do_rd(10'h2DC, "R3 port flag");
        do_rd(10'h2DB, "R3 data");
        do_wr(10'h2DB, 8'h00, "R4 flag ack");
        do_rd(10'h2DC, "R4 flag cleared nibble kept");
        do_wr(10'h3D1, 8'h3C, "R6 second trap");
        do_rd(10'h2DC, "R6 replaced port");
        do_rd(10'h3D7, "R7 shadow via 7");
        do_wr(10'h3D2, 8'h55, "R7 no shadow");
        do_rd(10'h3D1, "R7 shadow kept");
        do_wr(10'h2DC, 8'h00, "R5 nmi ack");
        do_rd(10'h2DC, "R5 flag cleared");
        // disarmed by control bit, then by global enable
        do_wr(10'h2D9, 8'h00, "R8");
        do_wr(10'h3DE, 8'h11, "R2 untrapped ctl");
        do_rd(10'h2DC, "R2 untrapped port");
        trap_global_en = 1'b0;
        do_wr(10'h2D9, 8'hE0, "R8");
        do_wr(10'h3D4, 8'h22, "R2 untrapped global");
        live_stat = 5'h15;
        do_rd(10'h2DA, "R8 native status");
        // legacy status polls
        disp_enable = 1'b0;
        do_rd(10'h3DA, "R9 poll 1");
        do_rd(10'h3DA, "R9 poll 2");
        do_rd(10'h3DA, "R9 poll 3");
        disp_enable = 1'b1; live_stat = 5'h1A;
        do_rd(10'h3DA, "R10 live");
        disp_enable = 1'b0;
        do_rd(10'h3DA, "R10 toggle untouched");
        // unmapped
        do_rd(10'h2D9, "R11 native 9");
        do_rd(10'h3D0, "R11 legacy 0");
        do_rd(10'h100, "R11 outside");

        // seeded random mix
        for (int i = 0; i < 3000; i++) begin
            logic [9:0] a;
            int k = $urandom_range(0, 9);
            case ($urandom_range(0, 2))
                0: a = {6'h3D, 4'($urandom_range(0, 15))};
                1: a = {6'h2D, 4'($urandom_range(0, 15))};
                default: a = 10'($urandom);
            endcase
            trap_global_en = ($urandom_range(0, 3) != 0);
            disp_enable    = $urandom_range(0, 1) != 0;
            live_stat      = 5'($urandom);
            if (k < 4)
                do_wr(a, 8'($urandom), "R2 random");
            else if (k == 4)
                do_wr(10'h2D9, $urandom_range(0, 1) != 0 ? 8'h20 : 8'($urandom), "R8 random");
            else
                do_rd(a, req_of(a));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule